// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches the running time and date of a real-time clock, held in packed BCD, and compares them with a programmable alarm word. The alarm word carries its own seconds, minutes, hours and day-of-month fields. A mask bit beside each field makes that field count as matching whatever its value. When every unmasked field agrees and the alarm is enabled, the block raises a sticky alarm flag. The flag drives an interrupt line when the interrupt enable is set.

The clock keeper pulses `tick_1hz` in the cycle in which the new second first appears on the time inputs. The flag is set only at a tick where the comparison result changes from false to true, so a match that holds over several seconds produces a single event. Software clears the flag with a write-one-to-clear strobe. Any change of the enable bit also clears it. Month and year are not compared.

Top module: `bcd_alarm`

## Requirements
- R1: After reset, `alarm_flag` and `alarm_irq` are 0.
- R2: Field positions in `alarm_word` are fixed: seconds in bits 6:0 (tens 6:4, units 3:0) against `cur_sec`, minutes in bits 14:8 against `cur_min`, hours in bits 22:16 (bit 22 is the PM flag, compared with `cur_hour[6]`) against `cur_hour`, and day of month in bits 29:24 against `cur_date`. When all unmasked fields are equal in a cycle with `tick_1hz`=1, `alarm_flag` is 1 from the following clock edge onward.
- R3: Mask bits sit at 7 (seconds), 15 (minutes), 23 (hours) and 31 (date). A field whose mask bit is 1 counts as matching regardless of its value. Bit 30 is not compared.
- R4: The flag sets only when the comparison result was false in the cycle before the tick. A match that is still true on a later tick does not set the flag again.
- R5: The flag never sets while `alarm_en` is 0.
- R6: A cycle with `clr_wr`=1 and `clr_bit`=1 clears the flag at the next edge. With `clr_bit`=0 the strobe has no effect. If a set event and a clear fall in the same cycle, the flag ends up set.
- R7: A cycle in which `alarm_en` differs from its value in the previous cycle clears the flag. This takes priority over a set event.
- R8: A change of `alarm_word` never creates an event. A word that differs from the previous cycle's word blocks the set in that cycle. A word that already matches the held time before the next tick does not fire at that tick.
- R9: With the seconds field unmasked, no match is possible while `prediv_s` is below 3. With seconds masked, `prediv_s` has no effect.
- R10: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `alarm_ie` is 1.
- R11: Once set, the flag holds until it is cleared by R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse; the time inputs show the new second in this cycle |
| cur_sec | input | 7 | Current seconds, BCD tens 6:4, units 3:0 |
| cur_min | input | 7 | Current minutes, BCD tens 6:4, units 3:0 |
| cur_hour | input | 7 | Current hours: bit 6 PM, BCD tens 5:4, units 3:0 |
| cur_date | input | 6 | Current day of month, BCD tens 5:4, units 3:0 |
| prediv_s | input | PRESC_W | Synchronous prescaler setting |
| alarm_word | input | 32 | Alarm fields and mask bits |
| alarm_en | input | 1 | Alarm enable |
| alarm_ie | input | 1 | Alarm interrupt enable |
| clr_wr | input | 1 | Write strobe to the clear register |
| clr_bit | input | 1 | Data bit 0 of the clear write |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Some rules are checked by the assertions on every cycle. A rising flag must follow a tick with the enable set. A clear strobe without a tick, or an enable toggle, must leave the flag low. A changed alarm word or an invalid seconds prescaler must never raise it. The flag must persist when nothing clears it. Other behaviours only show up in the bench's scenarios and its cycle model. These include the exact field layout and the PM bit, the per-field masks, and the one-event-per-rising-match rule over successive ticks. They also include set winning over a same-cycle clear, and the word that already matches before a tick.

// File: rtl/bcd_alarm_pkg.sv
// Shared constants for the BCD alarm comparator.
// Assumes alarm word fields sit on byte boundaries, mask bit at the top of each byte.
package bcd_alarm_pkg;
    localparam int ALARM_W      = 32;
    localparam int NUM_FIELDS   = 4;   // seconds, minutes, hours, date
    localparam int FIELD_STRIDE = 8;
    localparam int FIELD_W      = 7;
    localparam int DATE_W       = 6;
    localparam int MASK_OFS     = 7;

    // Width of the compared value bits of field idx
    function automatic int field_width(input int idx);
        return (idx == NUM_FIELDS - 1) ? DATE_W : FIELD_W;
    endfunction
endpackage

// File: rtl/bcd_field_cmp.sv
// Masked compare of one BCD field.
// Assumes both operands are already zero-extended to the same width.
module bcd_field_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] have,
    input  logic         ignore,
    output logic         hit
);
    // A masked field always counts as a hit
    always_comb hit = ignore || (want == have);
endmodule

// File: rtl/alarm_match.sv
// Combines per-field hits into one match, with the seconds prescaler rule.
// Assumes field 0 is the seconds field.
module alarm_match
    import bcd_alarm_pkg::*;
#(
    parameter int PRESC_W       = 15,
    parameter int MIN_SEC_PRESC = 3
) (
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] want_f,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] have_f,
    input  logic [NUM_FIELDS-1:0]              ign_f,
    input  logic [PRESC_W-1:0]                 prediv_s,
    output logic                               match
);
    logic [NUM_FIELDS-1:0] hits;
    logic                  sec_ok;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        bcd_field_cmp #(.W(FIELD_W)) u_cmp (
            .want   (want_f[i]),
            .have   (have_f[i]),
            .ignore (ign_f[i]),
            .hit    (hits[i])
        );
    end

    // Unmasked seconds need a prescaler large enough to resolve them
    always_comb sec_ok = ign_f[0] || (prediv_s >= PRESC_W'(MIN_SEC_PRESC));

    // Overall match needs every field and the seconds rule
    always_comb match = (&hits) && sec_ok;
endmodule

// File: rtl/alarm_edge.sv
// Turns the level match into a single set event per rising match at a tick.
// Assumes time inputs only change in tick cycles.
module alarm_edge
    import bcd_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               match,
    input  logic [ALARM_W-1:0] alarm_word,
    output logic               set_evt
);
    logic               last_match;
    logic [ALARM_W-1:0] word_q;

    // Remember last cycle's match and alarm word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_match <= 1'b0;
            word_q     <= '0;
        end else begin
            last_match <= match;
            word_q     <= alarm_word;
        end
    end

    // Event only at a tick, on a fresh match, with a word that did not just change
    always_comb set_evt = tick && match && !last_match && (alarm_word == word_q);
endmodule

// File: rtl/alarm_flag_reg.sv
// Sticky alarm flag: enable toggle clears first, then set, then write-one clear.
module alarm_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic alarm_en,
    input  logic clr_req,
    output logic flag
);
    logic en_q;

    // Track the enable bit to spot toggles
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= alarm_en;
    end

    // Flag update with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag <= 1'b0;
        else if (alarm_en != en_q)    flag <= 1'b0;
        else if (set_evt && alarm_en) flag <= 1'b1;
        else if (clr_req)             flag <= 1'b0;
    end
endmodule

// File: rtl/bcd_alarm.sv
// Top of the masked BCD calendar alarm comparator.
// Assumes the time inputs show the new second in the cycle of tick_1hz.
module bcd_alarm
    import bcd_alarm_pkg::*;
#(
    parameter int PRESC_W       = 15,
    parameter int MIN_SEC_PRESC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1hz,
    input  logic [6:0]         cur_sec,
    input  logic [6:0]         cur_min,
    input  logic [6:0]         cur_hour,
    input  logic [5:0]         cur_date,
    input  logic [PRESC_W-1:0] prediv_s,
    input  logic [ALARM_W-1:0] alarm_word,
    input  logic               alarm_en,
    input  logic               alarm_ie,
    input  logic               clr_wr,
    input  logic               clr_bit,
    output logic               alarm_flag,
    output logic               alarm_irq
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] want_f;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] have_f;
    logic [NUM_FIELDS-1:0]              ign_f;
    logic                               match;
    logic                               set_evt;

    // Slice the alarm word into fields and mask bits
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slice
        localparam int LSB = i * FIELD_STRIDE;
        localparam int W   = field_width(i);
        always_comb want_f[i] = FIELD_W'(alarm_word[LSB +: W]);
        always_comb ign_f[i]  = alarm_word[LSB + MASK_OFS];
    end

    // Gather the running time in field order
    always_comb begin
        have_f[0] = cur_sec;
        have_f[1] = cur_min;
        have_f[2] = cur_hour;
        have_f[3] = FIELD_W'(cur_date);
    end

    alarm_match #(.PRESC_W(PRESC_W), .MIN_SEC_PRESC(MIN_SEC_PRESC)) u_match (
        .want_f   (want_f),
        .have_f   (have_f),
        .ign_f    (ign_f),
        .prediv_s (prediv_s),
        .match    (match)
    );

    alarm_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1hz),
        .match      (match),
        .alarm_word (alarm_word),
        .set_evt    (set_evt)
    );

    alarm_flag_reg u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .alarm_en (alarm_en),
        .clr_req  (clr_wr && clr_bit),
        .flag     (alarm_flag)
    );

    // Interrupt follows the flag when enabled
    always_comb alarm_irq = alarm_flag && alarm_ie;
endmodule

// File: rtl/bcd_alarm_chk.sv
// Port-level properties of the alarm comparator, bound to every instance.
module bcd_alarm_chk #(
    parameter int PRESC_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_1hz,
    input logic [PRESC_W-1:0] prediv_s,
    input logic [31:0]        alarm_word,
    input logic               alarm_en,
    input logic               alarm_ie,
    input logic               clr_wr,
    input logic               clr_bit,
    input logic               alarm_flag,
    input logic               alarm_irq
);
    assert_set_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick_1hz && alarm_en));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bit && !tick_1hz) |=> !alarm_flag);

    assert_toggle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en != $past(alarm_en)) |=> !alarm_flag);

    assert_word_change_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_word != $past(alarm_word) && !alarm_flag) |=> !alarm_flag);

    assert_sec_presc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_word[7] && prediv_s < PRESC_W'(3) && !alarm_flag) |=> !alarm_flag);

    assert_irq_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm_flag) && alarm_ie) |-> alarm_irq);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(clr_wr && clr_bit) && alarm_en == $past(alarm_en)) |=> alarm_flag);
endmodule

bind bcd_alarm bcd_alarm_chk #(.PRESC_W(PRESC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .prediv_s   (prediv_s),
    .alarm_word (alarm_word),
    .alarm_en   (alarm_en),
    .alarm_ie   (alarm_ie),
    .clr_wr     (clr_wr),
    .clr_bit    (clr_bit),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/bcd_alarm_tb.sv
`timescale 1ns/1ps
module bcd_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [6:0]  cur_sec = 7'h55, cur_min = 7'h34, cur_hour = 7'h12;
    logic [5:0]  cur_date = 6'h21;
    logic [14:0] prediv_s = 15'd255;
    logic [31:0] alarm_word = 32'h0;
    logic        alarm_en = 1'b0, alarm_ie = 1'b0, clr_wr = 1'b0, clr_bit = 1'b0;
    logic        alarm_flag, alarm_irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic        m_flag = 1'b0, m_last = 1'b0, m_en = 1'b0;
    logic [31:0] m_word = 32'h0;

    localparam logic [31:0] W56 = 32'h21123456;

    always #4 clk = ~clk;

    bcd_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .prediv_s(prediv_s), .alarm_word(alarm_word), .alarm_en(alarm_en),
        .alarm_ie(alarm_ie), .clr_wr(clr_wr), .clr_bit(clr_bit),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // Expected comparison from the field layout (R2, R3, R9)
    function automatic logic exp_match(input logic [31:0] w, input logic [6:0] s,
                                       input logic [6:0] m, input logic [6:0] h,
                                       input logic [5:0] d, input logic [14:0] p);
        return (w[7]  || w[6:0]   == s) && (w[15] || w[14:8] == m) &&
               (w[23] || w[22:16] == h) && (w[31] || w[29:24] == d) &&
               (w[7]  || p >= 15'd3);
    endfunction

    task automatic report(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: update the bench model at the edge, compare 2 ns later
    task automatic step(input string tag);
        logic mt, ev, nf;
        @(posedge clk);
        if (!rst_n) begin
            m_flag = 0; m_last = 0; m_en = 0; m_word = 0;
        end else begin
            mt = exp_match(alarm_word, cur_sec, cur_min, cur_hour, cur_date, prediv_s);
            ev = tick_1hz && mt && !m_last && (alarm_word == m_word);
            if (alarm_en != m_en)       nf = 1'b0;
            else if (ev && alarm_en)    nf = 1'b1;
            else if (clr_wr && clr_bit) nf = 1'b0;
            else                        nf = m_flag;
            m_flag = nf; m_last = mt; m_en = alarm_en; m_word = alarm_word;
        end
        #2;
        report(tag, alarm_flag, m_flag, "flag vs model");
        report("R10", alarm_irq, m_flag && alarm_ie, "irq vs model");
    endtask

    task automatic tick_to(input logic [6:0] s, input string tag);
        cur_sec = s; tick_1hz = 1'b1;
        step(tag);
        tick_1hz = 1'b0;
    endtask

    task automatic clear_flag(input string tag);
        clr_wr = 1'b1; clr_bit = 1'b1;
        step(tag);
        clr_wr = 1'b0; clr_bit = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step("R1");
        rst_n = 1'b1;
        #1;
        report("R1", alarm_flag, 1'b0, "flag after reset");
        report("R1", alarm_irq, 1'b0, "irq after reset");

        // R2 basic match, R10 irq
        alarm_en = 1; alarm_ie = 1; alarm_word = W56;
        repeat (2) step("R7");
        tick_to(7'h55, "R2");
        tick_to(7'h56, "R2");
        report("R2", alarm_flag, 1'b1, "flag on match");
        report("R10", alarm_irq, 1'b1, "irq with ie");
        repeat (3) step("R11");
        report("R11", alarm_flag, 1'b1, "flag held");

        // R6 clear strobe with bit 0 low, then high
        clr_wr = 1; clr_bit = 0; step("R6");
        report("R6", alarm_flag, 1'b1, "clr_bit=0 ignored");
        clr_wr = 0;
        clear_flag("R6");
        report("R6", alarm_flag, 1'b0, "w1c clears");

        // R4 match still true on the next tick
        tick_to(7'h56, "R4");
        report("R4", alarm_flag, 1'b0, "no re-set while held");

        // R10 interrupt gated
        alarm_ie = 0;
        tick_to(7'h55, "R10"); tick_to(7'h56, "R10");
        report("R10", alarm_irq, 1'b0, "irq masked");
        report("R2", alarm_flag, 1'b1, "flag set with ie low");
        alarm_ie = 1; step("R10");
        report("R10", alarm_irq, 1'b1, "irq follows ie");

        // R6 set and clear in the same cycle
        clear_flag("R6");
        tick_to(7'h55, "R6");
        clr_wr = 1; clr_bit = 1; tick_to(7'h56, "R6");
        clr_wr = 0; clr_bit = 0;
        report("R6", alarm_flag, 1'b1, "set wins over clear");

        // R7 toggling the enable clears
        alarm_en = 0; step("R7");
        report("R7", alarm_flag, 1'b0, "disable clears");

        // R5 no set while disabled
        tick_to(7'h55, "R5"); tick_to(7'h56, "R5");
        report("R5", alarm_flag, 1'b0, "disabled no set");
        alarm_en = 1; step("R7");

        // R8 word change in tick cycle
        tick_to(7'h55, "R8");
        alarm_word = 32'h21123457; tick_to(7'h57, "R8");
        report("R8", alarm_flag, 1'b0, "word change at tick");
        tick_to(7'h59, "R8");
        alarm_word = 32'h21123459; repeat (3) step("R8");
        tick_to(7'h59, "R8");
        report("R8", alarm_flag, 1'b0, "pre-matched word");

        // R3 masked time fields, date compared
        alarm_word = 32'h22808080; step("R3");
        cur_date = 6'h21; tick_to(7'h00, "R3");
        cur_date = 6'h22; tick_to(7'h01, "R3");
        report("R3", alarm_flag, 1'b1, "masked fields match");
        clear_flag("R3");

        // R9 seconds unmasked with small prescaler
        cur_date = 6'h21; prediv_s = 15'd2; alarm_word = W56; step("R9");
        tick_to(7'h55, "R9"); tick_to(7'h56, "R9");
        report("R9", alarm_flag, 1'b0, "small prescaler blocks");
        alarm_word = W56 | 32'h80; step("R9");
        cur_min = 7'h33; tick_to(7'h10, "R9");
        cur_min = 7'h34; tick_to(7'h11, "R9");
        report("R9", alarm_flag, 1'b1, "masked seconds ignore prescaler");
        clear_flag("R9");
        prediv_s = 15'd255;

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0) begin
                tick_1hz = 1;
                cur_sec  = $urandom_range(1) ? 7'h56 : 7'h57;
                cur_min  = $urandom_range(1) ? 7'h34 : 7'h35;
                cur_hour = $urandom_range(1) ? 7'h12 : 7'h52;
                cur_date = $urandom_range(1) ? 6'h21 : 6'h22;
            end else tick_1hz = 0;
            if ($urandom_range(15) == 0) begin
                alarm_word = {$urandom_range(1) == 1, 1'b0,
                              ($urandom_range(1) ? 6'h21 : 6'h22),
                              $urandom_range(1) == 1, ($urandom_range(1) ? 7'h12 : 7'h52),
                              $urandom_range(1) == 1, ($urandom_range(1) ? 7'h34 : 7'h35),
                              $urandom_range(1) == 1, ($urandom_range(1) ? 7'h56 : 7'h57)};
            end
            if ($urandom_range(63) == 0) alarm_en = ~alarm_en;
            if ($urandom_range(31) == 0) alarm_ie = ~alarm_ie;
            if ($urandom_range(127) == 0) prediv_s = $urandom_range(1) ? 15'd2 : 15'd300;
            clr_wr  = ($urandom_range(15) == 0);
            clr_bit = $urandom_range(1) == 1;
            step("R4");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule